// File: doc/BRIEF.md
# Dual-Issue Pairing Dependency Checker

This block sits at the end of a decode stage that presents the two oldest decoded instructions every cycle. It decides whether the pair can leave together or whether only the older one may go. The younger one is then held for a later cycle. Each slot is described by a valid flag, a destination index with its write enable, two source indices with their use flags, and a three-bit operation class. The checker does not look at opcodes or operand values, and it does not fetch, read registers or execute anything.

Three independent conditions prevent pairing:
- the younger instruction reads a register that the older one writes;
- both instructions write the same register;
- both instructions need the single divider.

The decision is registered. The issue enables and the consumed count therefore appear one clock after the slot descriptors are presented. The surrounding decode queue uses the count to pop 0, 1 or 2 entries.

Top module: `pair_issue_check`

## Requirements
- R1: While `rst` is high at a rising clock edge, `issue_old`, `issue_young` and `issue_cnt` are all 0 after that edge, whatever the slot inputs are.
- R2: When both slots are valid and none of the hazards of R3, R4 and R5 is present, both issue enables are 1 and `issue_cnt` is 2 one clock after the inputs are presented.
- R3: When the older slot writes (`o_dst_we`=1) a nonzero register that the younger slot reads through a source whose use flag is 1, only the older slot issues on the next clock. This applies to either of the two younger sources.
- R4: When both slots have write enable 1 for the same nonzero destination, only the older slot issues on the next clock.
- R5: Class code 3 marks divide. When both slots carry class 3, only the older slot issues on the next clock. A single class-3 instruction paired with any other class (0 ALU, 1 multiply, 2 memory, 4 branch) does not block pairing.
- R6: A matching source whose use flag is 0, or a matching destination whose write enable is 0, does not prevent pairing.
- R7: Register index 0 never creates a dependence, neither as a read-after-write nor as a shared destination.
- R8: If the older slot is invalid, neither slot issues. If only the younger slot is invalid, the older slot issues alone.
- R9: `issue_cnt` always equals the number of asserted issue enables, and `issue_young` is never 1 while `issue_old` is 0.
- R10: An older instruction reading a register that the younger one writes (write-after-read inside the pair) does not prevent pairing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| o_valid | input | 1 | Older slot holds an instruction |
| o_dst | input | 5 | Older destination index |
| o_dst_we | input | 1 | Older writes its destination |
| o_src_a | input | 5 | Older first source index |
| o_src_a_use | input | 1 | Older first source is read |
| o_src_b | input | 5 | Older second source index |
| o_src_b_use | input | 1 | Older second source is read |
| o_cls | input | 3 | Older operation class |
| y_valid | input | 1 | Younger slot holds an instruction |
| y_dst | input | 5 | Younger destination index |
| y_dst_we | input | 1 | Younger writes its destination |
| y_src_a | input | 5 | Younger first source index |
| y_src_a_use | input | 1 | Younger first source is read |
| y_src_b | input | 5 | Younger second source index |
| y_src_b_use | input | 1 | Younger second source is read |
| y_cls | input | 3 | Younger operation class |
| issue_old | output | 1 | Older slot issues this cycle |
| issue_young | output | 1 | Younger slot issues this cycle |
| issue_cnt | output | 2 | Number of instructions consumed |

## Verification
Any fault in a hazard detector shows at the ports on the very next clock. A missed hazard appears as `issue_young` high with `issue_cnt` of 2 for a pair that must split. A false hazard splits an independent pair. The bench therefore compares every cycle against a behavioural model, mixing directed hazard cases with random traffic over a few register indices, so that collisions happen often. A stale or corrupted decision register is visible one cycle later as a count that disagrees with the enables, or as outputs surviving reset.

// File: rtl/pair_pkg.sv
package pair_pkg;
    localparam int REG_W   = 5;
    localparam int NSRC    = 2;
    localparam int CLS_W   = 3;
    localparam int CNT_W   = 2;

    typedef enum logic [CLS_W-1:0] {
        CLS_ALU = 3'd0,
        CLS_MUL = 3'd1,
        CLS_MEM = 3'd2,
        CLS_DIV = 3'd3,
        CLS_BR  = 3'd4
    } op_cls_e;

    typedef struct packed {
        logic                       valid;
        logic [REG_W-1:0]           dst;
        logic                       dst_we;
        logic [NSRC-1:0][REG_W-1:0] src;
        logic [NSRC-1:0]            src_use;
        logic [CLS_W-1:0]           cls;
    } slot_t;

    // A register reference counts only when enabled and not the zero register.
    function automatic logic ref_live(input logic [REG_W-1:0] idx, input logic en);
        return en && (idx != '0);
    endfunction
endpackage

// File: rtl/pair_raw_chk.sv
module pair_raw_chk
    import pair_pkg::*;
(
    input  slot_t older,
    input  slot_t younger,
    output logic  raw
);
    logic [NSRC-1:0] hit;
    logic            wr_live;

    assign wr_live = ref_live(older.dst, older.dst_we);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign hit[i] = wr_live
                     && ref_live(younger.src[i], younger.src_use[i])
                     && (younger.src[i] == older.dst);
    end

    assign raw = |hit;
endmodule

// File: rtl/pair_waw_chk.sv
module pair_waw_chk
    import pair_pkg::*;
(
    input  slot_t older,
    input  slot_t younger,
    output logic  waw
);
    assign waw = ref_live(older.dst, older.dst_we)
              && ref_live(younger.dst, younger.dst_we)
              && (older.dst == younger.dst);
endmodule

// File: rtl/pair_unit_chk.sv
module pair_unit_chk
    import pair_pkg::*;
#(
    parameter logic [CLS_W-1:0] UNIT_CLS = CLS_DIV
) (
    input  slot_t older,
    input  slot_t younger,
    output logic  clash
);
    assign clash = (older.cls == UNIT_CLS) && (younger.cls == UNIT_CLS);
endmodule

// File: rtl/pair_issue_check.sv
module pair_issue_check
    import pair_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 o_valid,
    input  logic [REG_W-1:0]     o_dst,
    input  logic                 o_dst_we,
    input  logic [REG_W-1:0]     o_src_a,
    input  logic                 o_src_a_use,
    input  logic [REG_W-1:0]     o_src_b,
    input  logic                 o_src_b_use,
    input  logic [CLS_W-1:0]     o_cls,
    input  logic                 y_valid,
    input  logic [REG_W-1:0]     y_dst,
    input  logic                 y_dst_we,
    input  logic [REG_W-1:0]     y_src_a,
    input  logic                 y_src_a_use,
    input  logic [REG_W-1:0]     y_src_b,
    input  logic                 y_src_b_use,
    input  logic [CLS_W-1:0]     y_cls,
    output logic                 issue_old,
    output logic                 issue_young,
    output logic [CNT_W-1:0]     issue_cnt
);
    slot_t older, younger;
    logic  raw, waw, clash, split;

    always_comb begin
        older.valid      = o_valid;
        older.dst        = o_dst;
        older.dst_we     = o_dst_we;
        older.src[0]     = o_src_a;
        older.src[1]     = o_src_b;
        older.src_use[0] = o_src_a_use;
        older.src_use[1] = o_src_b_use;
        older.cls        = o_cls;
        younger.valid      = y_valid;
        younger.dst        = y_dst;
        younger.dst_we     = y_dst_we;
        younger.src[0]     = y_src_a;
        younger.src[1]     = y_src_b;
        younger.src_use[0] = y_src_a_use;
        younger.src_use[1] = y_src_b_use;
        younger.cls        = y_cls;
    end

    pair_raw_chk u_raw (.older(older), .younger(younger), .raw(raw));
    pair_waw_chk u_waw (.older(older), .younger(younger), .waw(waw));
    pair_unit_chk #(.UNIT_CLS(CLS_DIV)) u_div (.older(older), .younger(younger), .clash(clash));

    assign split = raw | waw | clash;

    always_ff @(posedge clk) begin
        if (rst) begin
            issue_old   <= 1'b0;
            issue_young <= 1'b0;
            issue_cnt   <= '0;
        end else begin
            issue_old   <= older.valid;
            issue_young <= older.valid && younger.valid && !split;
            if (!older.valid)
                issue_cnt <= CNT_W'(0);
            else if (younger.valid && !split)
                issue_cnt <= CNT_W'(2);
            else
                issue_cnt <= CNT_W'(1);
        end
    end

    // R9: the younger never leaves ahead of the older
    p_young_needs_old_r9: assert property (@(posedge clk) disable iff (rst)
        issue_young |-> issue_old);

    // R9: count agrees with the enables
    p_cnt_matches_r9: assert property (@(posedge clk) disable iff (rst)
        issue_cnt == CNT_W'($countones({issue_old, issue_young})));

    // R8: empty older slot issues nothing
    p_no_old_no_issue_r8: assert property (@(posedge clk) disable iff (rst)
        !o_valid |=> (!issue_old && !issue_young));

    // R4: shared nonzero destination splits the pair
    p_shared_dst_split_r4: assert property (@(posedge clk) disable iff (rst)
        (o_valid && y_valid && o_dst_we && y_dst_we && o_dst != '0 && o_dst == y_dst)
        |=> (issue_old && !issue_young));

    // R5: two divides never leave together
    p_one_divider_r5: assert property (@(posedge clk) disable iff (rst)
        (o_valid && y_valid && o_cls == CLS_DIV && y_cls == CLS_DIV)
        |=> !issue_young);

    // R3: true dependence through the first younger source splits the pair
    p_raw_a_split_r3: assert property (@(posedge clk) disable iff (rst)
        (o_valid && y_valid && o_dst_we && o_dst != '0 && y_src_a_use && y_src_a == o_dst)
        |=> !issue_young);

    // R1: reset clears the decision
    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (!issue_old && !issue_young && issue_cnt == '0));
endmodule

// File: tb/pair_issue_check_test.sv
`timescale 1ns/1ps
module pair_issue_check_test;
    import pair_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    slot_t o_s, y_s;
    logic issue_old, issue_young;
    logic [CNT_W-1:0] issue_cnt;
    int checks = 0;
    int fails  = 0;

    pair_issue_check uut (
        .clk(clk), .rst(rst),
        .o_valid(o_s.valid), .o_dst(o_s.dst), .o_dst_we(o_s.dst_we),
        .o_src_a(o_s.src[0]), .o_src_a_use(o_s.src_use[0]),
        .o_src_b(o_s.src[1]), .o_src_b_use(o_s.src_use[1]), .o_cls(o_s.cls),
        .y_valid(y_s.valid), .y_dst(y_s.dst), .y_dst_we(y_s.dst_we),
        .y_src_a(y_s.src[0]), .y_src_a_use(y_s.src_use[0]),
        .y_src_b(y_s.src[1]), .y_src_b_use(y_s.src_use[1]), .y_cls(y_s.cls),
        .issue_old(issue_old), .issue_young(issue_young), .issue_cnt(issue_cnt)
    );

    function automatic slot_t mk(input bit v, input int d, input bit we,
                                 input int a, input bit ua, input int b, input bit ub,
                                 input int c);
        slot_t s;
        s.valid = v; s.dst = REG_W'(d); s.dst_we = we;
        s.src[0] = REG_W'(a); s.src_use[0] = ua;
        s.src[1] = REG_W'(b); s.src_use[1] = ub;
        s.cls = CLS_W'(c);
        return s;
    endfunction

    // Behavioural reference: how many of the pair may leave this cycle.
    function automatic int model_count(input slot_t o, input slot_t y);
        int reads[$];
        bit blocked;
        if (!o.valid) return 0;
        if (!y.valid) return 1;
        if (y.src_use[0] && y.src[0] != 0) reads.push_back(int'(y.src[0]));
        if (y.src_use[1] && y.src[1] != 0) reads.push_back(int'(y.src[1]));
        blocked = 0;
        if (o.dst_we && o.dst != 0)
            foreach (reads[k]) if (reads[k] == int'(o.dst)) blocked = 1;
        if (o.dst_we && y.dst_we && o.dst != 0 && o.dst == y.dst) blocked = 1;
        if (int'(o.cls) == 3 && int'(y.cls) == 3) blocked = 1;
        return blocked ? 1 : 2;
    endfunction

    task automatic compare(input int exp_n, input string tag);
        logic [3:0] got, want;
        got  = {issue_old, issue_young, issue_cnt};
        want = {exp_n >= 1, exp_n == 2, 2'(exp_n)};
        checks++;
        if (got !== want) begin
            fails++;
            $display("FAIL %s: old/young/cnt actual %b/%b/%0d expected %b/%b/%0d",
                     tag, issue_old, issue_young, issue_cnt,
                     want[3], want[2], want[1:0]);
        end
    endtask

    task automatic apply(input slot_t o, input slot_t y, input string tag);
        @(negedge clk);
        o_s = o; y_s = y;
        @(posedge clk);
        #2;
        compare(rst ? 0 : model_count(o, y), tag);
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        o_s = mk(0,0,0,0,0,0,0,0);
        y_s = mk(0,0,0,0,0,0,0,0);
        // R1: reset holds outputs low even with valid slots
        apply(mk(1,1,1,2,1,3,1,0), mk(1,4,1,5,1,6,1,0), "R1 reset");
        apply(mk(1,1,1,2,1,3,1,0), mk(1,1,1,1,1,6,1,0), "R1 reset");
        @(negedge clk); rst = 1'b0;
        // R2: independent pair
        apply(mk(1,1,1,2,1,3,1,0), mk(1,4,1,5,1,6,1,1), "R2 independent");
        apply(mk(1,7,1,8,1,9,1,2), mk(1,10,1,11,1,12,1,4), "R2 independent");
        // R3: RAW through either younger source
        apply(mk(1,5,1,1,1,2,1,0), mk(1,6,1,5,1,2,1,0), "R3 raw src a");
        apply(mk(1,5,1,1,1,2,1,0), mk(1,6,1,3,1,5,1,0), "R3 raw src b");
        // R4: shared destination
        apply(mk(1,9,1,1,1,2,1,0), mk(1,9,1,3,1,4,1,1), "R4 shared dst");
        // R5: two divides vs divide with other class
        apply(mk(1,1,1,2,1,3,1,3), mk(1,4,1,5,1,6,1,3), "R5 two divides");
        apply(mk(1,1,1,2,1,3,1,3), mk(1,4,1,5,1,6,1,1), "R5 divide plus mul");
        // R6: unused source, disabled write
        apply(mk(1,5,1,1,1,2,1,0), mk(1,6,1,5,0,5,0,0), "R6 unused sources");
        apply(mk(1,5,0,1,1,2,1,0), mk(1,5,1,5,1,2,1,0), "R6 older no write");
        // R7: register zero
        apply(mk(1,0,1,1,1,2,1,0), mk(1,0,1,0,1,0,1,0), "R7 zero register");
        // R8: invalid slots
        apply(mk(0,1,1,2,1,3,1,0), mk(1,4,1,5,1,6,1,0), "R8 older invalid");
        apply(mk(1,1,1,2,1,3,1,0), mk(0,4,1,5,1,6,1,0), "R8 younger invalid");
        apply(mk(0,1,1,2,1,3,1,3), mk(0,1,1,1,1,6,1,3), "R8 both invalid");
        // R10: older reads what younger writes
        apply(mk(1,1,1,7,1,8,1,0), mk(1,7,1,2,1,3,1,0), "R10 war inside pair");
        // R9: random traffic over a small register range
        for (int n = 0; n < 600; n++) begin
            apply(mk($urandom_range(0,1) == 0 ? 0 : ($urandom_range(0,7) != 0),
                     $urandom_range(0,3), $urandom_range(0,1),
                     $urandom_range(0,3), $urandom_range(0,1),
                     $urandom_range(0,3), $urandom_range(0,1), $urandom_range(0,4)) | '0,
                  mk($urandom_range(0,7) != 0,
                     $urandom_range(0,3), $urandom_range(0,1),
                     $urandom_range(0,3), $urandom_range(0,1),
                     $urandom_range(0,3), $urandom_range(0,1), $urandom_range(0,4)),
                  "R9 random");
        end
        // R1: reset again after traffic
        @(negedge clk); rst = 1'b1;
        apply(mk(1,1,1,2,1,3,1,0), mk(1,4,1,5,1,6,1,0), "R1 re-reset");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule